// File: doc/BRIEF.md
# Reverse Reference Clock Link Sequencer

This block runs the reference-clock link that travels backwards, from the receiving (host) end of a camera link to the transmitting (camera) end. A single module holds both halves, and a 2-bit role input selects which half is live. In the host role, releasing power-down takes the outgoing line out of its off condition. The line then passes through a counted low / high / low wake-up pattern and after that carries the reference clock. In the camera role, the block watches the incoming line and checks the length of each wake-up phase. Once it sees the clock, it lets seven clock cycles pass and then enables its local clock output. That output is the condition that allows the serializer to start.

The line is modelled as a 2-bit symbol: `00` off (no current), `01` driven low, `10` driven high, `11` clock running. The block steps on its reference clock, which has no phase or frequency relationship to the pixel or serial data clocks. Analog line levels are not modelled.

Host states: `H_OFF`, `H_LEAD_LO`, `H_MID_HI`, `H_TAIL_LO`, `H_FWD`. Transitions are: off to lead-low when the role is enabled, each phase to the next after `PH_LEN` cycles, tail-low to forwarding, and any state to off when disabled.

Camera states: `C_OFF`, `C_ARMED`, `C_LEAD_LO`, `C_MID_HI`, `C_TAIL_LO`, `C_SETTLE`, `C_ON`, `C_FAULT`.
- Off goes to armed when enabled.
- Armed goes to lead-low on a low symbol.
- A phase advances on the next expected symbol when its length is inside the window, and goes to fault otherwise.
- Settle goes to on after `EN_DLY` clock symbols.
- Any active state goes back to armed when the line goes off.
- Any unexpected symbol leads to fault, and fault goes to armed once the line is off.

Top module: `rclk_link_seq`

## Requirements
- R1: While `pd_n` is 0, `line_tx` is `00` and `lclk_en` and `clk_ready` are 0 in the same cycle, whatever the role; a reset gives the same outputs.
- R2: With `mode` set to `10` or `11`, `line_tx` stays `00` and `lclk_en` stays 0, whatever arrives on `line_rx`.
- R3: In host role (`mode` = `00`), starting in the first cycle after `pd_n` is sampled high, `line_tx` shows `01` for `PH_LEN` cycles, then `10` for `PH_LEN` cycles, then `01` for `PH_LEN` cycles, then `11` for as long as the role stays enabled.
- R4: In host role, `lclk_en` and `clk_ready` stay 0 and `line_rx` has no effect.
- R5: In camera role (`mode` = `01`), `line_tx` stays `00`.
- R6: In camera role, a pattern of `01`, `10`, `01` runs with each run length between `PH_MIN` and `PH_MAX` inclusive, followed by `11`, raises `lclk_en` after exactly `EN_DLY` cycles of `11` have been sampled.
- R7: If any phase length falls outside the window, or a symbol arrives out of order, `lclk_en` stays 0 until the line has been `00` for at least one cycle. After that a fresh valid pattern is accepted.
- R8: `clk_ready` is 1 for exactly one cycle, the first cycle in which `lclk_en` is 1.
- R9: Once `lclk_en` is 1, a sampled `00` or any symbol other than `11` on `line_rx` drops `lclk_en` in the next cycle.
- R10: After `pd_n` or `mode` leaves and returns to a role, the sequence restarts from the beginning. The host replays the full pattern, and the camera requires a new pattern before enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Role: 00 host, 01 camera, 10/11 reserved (off) |
| pd_n | input | 1 | Power-down, active low |
| line_rx | input | 2 | Incoming reference-line symbol (camera role) |
| line_tx | output | 2 | Outgoing reference-line symbol (host role) |
| lclk_en | output | 1 | Local clock output enable, camera role |
| clk_ready | output | 1 | One-cycle pulse when the local clock is first enabled |

## Verification
The bench builds the block with its defaults: `PH_LEN` 12, a window of 11 to 13 and a delay of 7. It then sweeps every combination of three phase lengths from 9 to 15. Two lengths on each side of both window edges are therefore exercised in every phase position, so an off-by-one at either bound, in any phase, changes the result. The seven-cycle delay is short enough to check the exact enable cycle and the ready pulse after each accepted pattern. The 36-cycle host pattern is traced symbol by symbol after power-up, after a power-down pulse mid-pattern, and while a stray pattern is present on the input.

// File: rtl/rclk_pkg.sv
package rclk_pkg;

    // Line symbol on the reference link
    typedef enum logic [1:0] {
        LN_OFF  = 2'b00,
        LN_LOW  = 2'b01,
        LN_HIGH = 2'b10,
        LN_CLK  = 2'b11
    } line_e;

    // Role codes
    localparam logic [1:0] ROLE_HOST = 2'b00;
    localparam logic [1:0] ROLE_CAM  = 2'b01;

    typedef enum logic [2:0] {
        H_OFF,
        H_LEAD_LO,
        H_MID_HI,
        H_TAIL_LO,
        H_FWD
    } host_st_e;

    typedef enum logic [2:0] {
        C_OFF,
        C_ARMED,
        C_LEAD_LO,
        C_MID_HI,
        C_TAIL_LO,
        C_SETTLE,
        C_ON,
        C_FAULT
    } cam_st_e;

endpackage

// File: rtl/rclk_mode_dec.sv
module rclk_mode_dec
    import rclk_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       pd_n,
    output logic       host_run,
    output logic       cam_run
);

    // Reserved codes enable neither role
    always_comb begin
        host_run = 1'b0;
        cam_run  = 1'b0;
        if (pd_n) begin
            unique case (mode)
                ROLE_HOST: host_run = 1'b1;
                ROLE_CAM:  cam_run  = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rclk_host_fsm.sv
module rclk_host_fsm
    import rclk_pkg::*;
#(
    parameter int PH_LEN = 12,
    parameter int CW     = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    output line_e line_o
);

    localparam logic [CW-1:0] PH_LAST = CW'(PH_LEN - 1);
    localparam logic [CW-1:0] ONE     = CW'(1);

    host_st_e        st, nx;
    logic [CW-1:0]   cnt, cnt_nx;
    logic            ph_done;

    assign ph_done = (cnt == PH_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= H_OFF;
            cnt <= '0;
        end else begin
            st  <= nx;
            cnt <= cnt_nx;
        end
    end

    // Next state
    always_comb begin
        nx     = st;
        cnt_nx = cnt + ONE;
        if (!run) begin
            nx     = H_OFF;
            cnt_nx = '0;
        end else begin
            unique case (st)
                H_OFF: begin
                    nx     = H_LEAD_LO;
                    cnt_nx = '0;
                end
                H_LEAD_LO: if (ph_done) begin
                    nx     = H_MID_HI;
                    cnt_nx = '0;
                end
                H_MID_HI: if (ph_done) begin
                    nx     = H_TAIL_LO;
                    cnt_nx = '0;
                end
                H_TAIL_LO: if (ph_done) begin
                    nx     = H_FWD;
                    cnt_nx = '0;
                end
                H_FWD: cnt_nx = cnt;
                default: begin
                    nx     = H_OFF;
                    cnt_nx = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (st)
            H_LEAD_LO: line_o = LN_LOW;
            H_MID_HI:  line_o = LN_HIGH;
            H_TAIL_LO: line_o = LN_LOW;
            H_FWD:     line_o = LN_CLK;
            default:   line_o = LN_OFF;
        endcase
    end

endmodule

// File: rtl/rclk_cam_fsm.sv
module rclk_cam_fsm
    import rclk_pkg::*;
#(
    parameter int PH_MIN = 11,
    parameter int PH_MAX = 13,
    parameter int EN_DLY = 7,
    parameter int CW     = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  line_e line_i,
    output logic  en_o,
    output logic  rdy_o
);

    localparam logic [CW-1:0] ONE       = CW'(1);
    localparam logic [CW-1:0] WIN_LO    = CW'(PH_MIN);
    localparam logic [CW-1:0] WIN_HI    = CW'(PH_MAX);
    localparam logic [CW-1:0] DLY_LAST  = CW'(EN_DLY - 1);

    cam_st_e       st, nx;
    logic [CW-1:0] cnt, cnt_nx, cnt_inc;
    logic          in_win;
    logic          on_q;

    // Saturating run-length counter
    assign cnt_inc = (&cnt) ? cnt : cnt + ONE;
    assign in_win  = (cnt >= WIN_LO) && (cnt <= WIN_HI);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= C_OFF;
            cnt  <= '0;
            on_q <= 1'b0;
        end else begin
            st   <= nx;
            cnt  <= cnt_nx;
            on_q <= (st == C_ON);
        end
    end

    // Next state
    always_comb begin
        nx     = st;
        cnt_nx = cnt;
        if (!run) begin
            nx     = C_OFF;
            cnt_nx = '0;
        end else begin
            unique case (st)
                C_OFF: begin
                    nx     = C_ARMED;
                    cnt_nx = '0;
                end
                C_ARMED: begin
                    case (line_i)
                        LN_LOW: begin
                            nx     = C_LEAD_LO;
                            cnt_nx = ONE;
                        end
                        LN_OFF:  nx = C_ARMED;
                        default: nx = C_FAULT;
                    endcase
                end
                C_LEAD_LO: begin
                    case (line_i)
                        LN_LOW:  cnt_nx = cnt_inc;
                        LN_HIGH: begin
                            nx     = in_win ? C_MID_HI : C_FAULT;
                            cnt_nx = ONE;
                        end
                        LN_OFF: begin
                            nx     = C_ARMED;
                            cnt_nx = '0;
                        end
                        default: nx = C_FAULT;
                    endcase
                end
                C_MID_HI: begin
                    case (line_i)
                        LN_HIGH: cnt_nx = cnt_inc;
                        LN_LOW: begin
                            nx     = in_win ? C_TAIL_LO : C_FAULT;
                            cnt_nx = ONE;
                        end
                        LN_OFF: begin
                            nx     = C_ARMED;
                            cnt_nx = '0;
                        end
                        default: nx = C_FAULT;
                    endcase
                end
                C_TAIL_LO: begin
                    case (line_i)
                        LN_LOW: cnt_nx = cnt_inc;
                        LN_CLK: begin
                            nx     = in_win ? C_SETTLE : C_FAULT;
                            cnt_nx = ONE;
                        end
                        LN_OFF: begin
                            nx     = C_ARMED;
                            cnt_nx = '0;
                        end
                        default: nx = C_FAULT;
                    endcase
                end
                C_SETTLE: begin
                    case (line_i)
                        LN_CLK: begin
                            if (cnt == DLY_LAST) begin
                                nx     = C_ON;
                                cnt_nx = '0;
                            end else begin
                                cnt_nx = cnt_inc;
                            end
                        end
                        LN_OFF: begin
                            nx     = C_ARMED;
                            cnt_nx = '0;
                        end
                        default: nx = C_FAULT;
                    endcase
                end
                C_ON: begin
                    case (line_i)
                        LN_CLK: nx = C_ON;
                        LN_OFF: begin
                            nx     = C_ARMED;
                            cnt_nx = '0;
                        end
                        default: nx = C_FAULT;
                    endcase
                end
                C_FAULT: begin
                    if (line_i == LN_OFF) begin
                        nx     = C_ARMED;
                        cnt_nx = '0;
                    end
                end
                default: begin
                    nx     = C_OFF;
                    cnt_nx = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        en_o  = (st == C_ON);
        rdy_o = (st == C_ON) && !on_q;
    end

endmodule

// File: rtl/rclk_link_seq.sv
module rclk_link_seq
    import rclk_pkg::*;
#(
    parameter int PH_LEN = 12,
    parameter int PH_MIN = 11,
    parameter int PH_MAX = 13,
    parameter int EN_DLY = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       pd_n,
    input  logic [1:0] line_rx,
    output logic [1:0] line_tx,
    output logic       lclk_en,
    output logic       clk_ready
);

    localparam int CNT_A   = (PH_LEN > PH_MAX) ? PH_LEN : PH_MAX;
    localparam int CNT_TOP = (CNT_A > EN_DLY) ? CNT_A : EN_DLY;
    localparam int CW      = $clog2(CNT_TOP + 2);

    logic  host_run, cam_run;
    line_e host_line;
    logic  cam_en, cam_rdy;

    rclk_mode_dec u_dec (
        .mode     (mode),
        .pd_n     (pd_n),
        .host_run (host_run),
        .cam_run  (cam_run)
    );

    rclk_host_fsm #(
        .PH_LEN (PH_LEN),
        .CW     (CW)
    ) u_host (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (host_run),
        .line_o (host_line)
    );

    rclk_cam_fsm #(
        .PH_MIN (PH_MIN),
        .PH_MAX (PH_MAX),
        .EN_DLY (EN_DLY),
        .CW     (CW)
    ) u_cam (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cam_run),
        .line_i (line_e'(line_rx)),
        .en_o   (cam_en),
        .rdy_o  (cam_rdy)
    );

    // Power-down and role gating act in the same cycle
    assign line_tx   = host_run ? host_line : LN_OFF;
    assign lclk_en   = cam_en  & cam_run;
    assign clk_ready = cam_rdy & cam_run;

endmodule

// File: rtl/rclk_link_seq_chk.sv
module rclk_link_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       pd_n,
    input logic [1:0] line_rx,
    input logic [1:0] line_tx,
    input logic       lclk_en,
    input logic       clk_ready
);

    assert_down_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |-> (line_tx == 2'b00 && !lclk_en && !clk_ready));

    assert_reserved_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |-> (line_tx == 2'b00 && !lclk_en && !clk_ready));

    assert_leave_off_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(line_tx) == 2'b00 && line_tx != 2'b00) |-> line_tx == 2'b01);

    assert_fwd_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && pd_n && $past(mode == 2'b00 && pd_n) && $past(line_tx) == 2'b11)
            |-> line_tx == 2'b11);

    assert_host_no_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b00 |-> (!lclk_en && !clk_ready));

    assert_cam_tx_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b01 |-> line_tx == 2'b00);

    assert_enable_after_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lclk_en) |-> ($past(line_rx) == 2'b11));

    assert_ready_with_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_ready |-> lclk_en);

    assert_ready_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_ready |=> !clk_ready);

    assert_ready_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lclk_en) |-> clk_ready);

    assert_drop_on_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lclk_en && line_rx != 2'b11) |=> !lclk_en);

endmodule

bind rclk_link_seq rclk_link_seq_chk u_chk (.*);

// File: tb/rclk_link_seq_test.sv
`timescale 1ns/1ps
module rclk_link_seq_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode;
    logic       pd_n;
    logic [1:0] line_rx;
    logic [1:0] line_tx;
    logic       lclk_en;
    logic       clk_ready;

    int tests = 0;
    int fails = 0;

    localparam int PH  = 12;
    localparam int WLO = 11;
    localparam int WHI = 13;
    localparam int DLY = 7;

    always #5 clk = ~clk;

    rclk_link_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .pd_n      (pd_n),
        .line_rx   (line_rx),
        .line_tx   (line_tx),
        .lclk_en   (lclk_en),
        .clk_ready (clk_ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one symbol for one cycle; return just after the edge
    task automatic drv(input logic [1:0] s);
        line_rx = s;
        @(posedge clk);
        #1;
    endtask

    task automatic hold(input logic [1:0] s, input int n);
        for (int i = 0; i < n; i++) drv(s);
    endtask

    // Camera pattern with three phase lengths, then ten clock symbols
    task automatic pat(input int a, input int b, input int c, input bit ok, input string tag);
        hold(2'b00, 2);
        hold(2'b01, a);
        hold(2'b10, b);
        hold(2'b01, c);
        chk(tag, lclk_en, 0);
        for (int i = 1; i <= 10; i++) begin
            drv(2'b11);
            if (i == 1) chk(mode == 2'b01 ? "R5" : tag, line_tx, 0);
            if (i == DLY - 1 || i == DLY || i == DLY + 1)
                chk(tag, lclk_en, (ok && i >= DLY) ? 1 : 0);
            if (i == DLY || i == DLY + 1)
                chk("R8", clk_ready, (ok && i == DLY) ? 1 : 0);
        end
    endtask

    // Host pattern trace from the cycle after enabling
    task automatic host_trace(input string tag, input int n);
        for (int i = 1; i <= n; i++) begin
            @(posedge clk);
            #1;
            chk(tag, line_tx, (i <= PH) ? 1 : (i <= 2*PH) ? 2 : (i <= 3*PH) ? 1 : 3);
            chk("R4", lclk_en + clk_ready, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = 2'b00; pd_n = 1'b0; line_rx = 2'b00;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", line_tx, 0);
        chk("R1", lclk_en, 0);
        chk("R1", clk_ready, 0);
        rst_n = 1'b1;
        hold(2'b00, 2);
        chk("R1", line_tx, 0);

        // Host role, with a stray clock on the input (R4)
        line_rx = 2'b11;
        pd_n = 1'b1;
        host_trace("R3", 3*PH + 8);
        pd_n = 1'b0;
        #1 chk("R1", line_tx, 0);
        @(posedge clk); #1;
        pd_n = 1'b1;
        host_trace("R10", 20);
        pd_n = 1'b0;
        @(posedge clk); #1;
        pd_n = 1'b1;
        host_trace("R10", 3*PH + 4);

        // Camera role: exhaustive phase-length sweep
        pd_n = 1'b0;
        hold(2'b00, 1);
        mode = 2'b01; pd_n = 1'b1;
        hold(2'b00, 2);
        for (int a = 9; a <= 15; a++)
            for (int b = 9; b <= 15; b++)
                for (int c = 9; c <= 15; c++) begin
                    bit ok;
                    ok = (a >= WLO && a <= WHI && b >= WLO && b <= WHI && c >= WLO && c <= WHI);
                    pat(a, b, c, ok, ok ? "R6" : "R7");
                    drv(2'b00);
                    chk("R9", lclk_en, 0);
                end

        // Out-of-order symbols lead to fault
        hold(2'b00, 2);
        hold(2'b10, 12);
        hold(2'b01, 12);
        hold(2'b11, 12);
        chk("R7", lclk_en, 0);
        pat(12, 12, 12, 1'b1, "R7");

        // Non-clock symbol while on drops output, stays faulted
        drv(2'b01);
        chk("R9", lclk_en, 0);
        hold(2'b11, 12);
        chk("R7", lclk_en, 0);
        pat(11, 13, 12, 1'b1, "R7");

        // Interruption during settle
        hold(2'b00, 2);
        hold(2'b01, 12); hold(2'b10, 12); hold(2'b01, 12);
        hold(2'b11, 3);
        drv(2'b10);
        hold(2'b11, 10);
        chk("R7", lclk_en, 0);

        // Power-down in camera role gates at once, then needs a new pattern
        pat(12, 12, 12, 1'b1, "R6");
        pd_n = 1'b0;
        #1 chk("R1", lclk_en, 0);
        chk("R1", clk_ready, 0);
        drv(2'b11);
        pd_n = 1'b1;
        hold(2'b11, 10);
        chk("R10", lclk_en, 0);

        // Role switch away and back
        pat(13, 11, 13, 1'b1, "R6");
        mode = 2'b00;
        drv(2'b11);
        chk("R4", lclk_en, 0);
        mode = 2'b01;
        hold(2'b11, 10);
        chk("R10", lclk_en, 0);

        // Reserved codes
        mode = 2'b10;
        pat(12, 12, 12, 1'b0, "R2");
        chk("R2", line_tx, 0);
        mode = 2'b11;
        pat(12, 12, 12, 1'b0, "R2");
        chk("R2", line_tx, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule